// File: doc/BRIEF.md
# Multi-Source Staged Reset Sequencer

This block collects every reset request of a chip and turns them into three active-high reset outputs that release one after another. The requests are a power-on indication, an active-low external reset pin, a watchdog timeout and a software request. Any request sets all three outputs at once, with no clock needed. Release is paced by counters. The clock-generator reset releases first, counted on a free-running oscillator clock. The peripheral reset and then the core reset follow, each counted on the system clock.

A power-on request is stretched on the oscillator clock before it joins the other requests. The other three requests first pass through a two-flop synchronizer with asynchronous set. Each delay stage also synchronizes its own input, so no counter is released by an unsynchronized edge. A status output records which request started the most recent reset sequence. A power-on request is the only thing that resets that record.

Top module: `rst_seq_top`

## Requirements
- R1: After `por_n` rises just after an oscillator rising edge, `clkgen_rst` stays high and falls on the 96th oscillator rising edge after that point. This is 64 cycles of power-on stretch plus 32 cycles of clock-generator delay.
- R2: Asserting any request sets `clkgen_rst`, `periph_rst` and `core_rst` high at once, without any clock edge. The requests are `por_n` low, `ext_rst_n` low, `wdog_rst` high or `sw_rst` high.
- R3: When the last active external, watchdog or software request releases just after an oscillator rising edge, `clkgen_rst` falls on the 34th oscillator rising edge after that point. This is 2 synchronizer cycles plus 32 delay cycles.
- R4: If a request reasserts while a release count is running, even as a pulse shorter than a clock period, the count restarts. The full delay is then measured from the final release.
- R5: `periph_rst` falls on the 32nd system-clock rising edge after `clkgen_rst` falls.
- R6: `core_rst` falls on the 32nd system-clock rising edge after `periph_rst` falls. The outputs never release out of order.
- R7: While `clkgen_rst` is high, `periph_rst` and `core_rst` stay high even if the system clock is stopped. After `clkgen_rst` falls they do not release until the system clock runs again.
- R8: `cause` is one-hot. Bit 0 is power-on, bit 1 is external, bit 2 is watchdog and bit 3 is software. The value is captured on the first oscillator edge of a new sequence. Requests that arrive while that sequence is still in progress do not change it.
- R9: `cause` is set to 4'b0001 at once by a power-on request. External, watchdog and software requests never clear it.
- R10: `ext_rst_n` is active low. `wdog_rst` and `sw_rst` are active high. With `ext_rst_n` high and the other two low, no reset is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running oscillator clock |
| sys_clk | input | 1 | System clock; may be stopped |
| por_n | input | 1 | Power-on indication, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_rst | input | 1 | Watchdog timeout request, active high, asynchronous |
| sw_rst | input | 1 | Software reset request, active high, asynchronous |
| clkgen_rst | output | 1 | Clock-generator reset, active high |
| periph_rst | output | 1 | Peripheral reset, active high |
| core_rst | output | 1 | Core reset, active high |
| cause | output | 4 | One-hot record of the request that started the last sequence |

## Verification
The bench builds the block with its default counts: a 64-cycle power-on stretch, a 32-cycle oscillator stage and two 32-cycle system stages, with two synchronizer flops. Every release edge can therefore be predicted as an exact edge number: 96 and 34 oscillator edges, and 32 plus 32 system edges. The two clocks have unrelated periods whose edges never coincide, so each output is checked on the edge before its release as well as on the release edge itself. These counts are also short enough for the bench to cover the glitch restart, the stopped system clock and repeated random requests.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;
  localparam int NUM_SRC  = 3;            // external, watchdog, software
  localparam int CAUSE_W  = NUM_SRC + 1;  // plus power-on
  localparam int CAUSE_POR = 0;
  typedef logic [CAUSE_W-1:0] cause_t;
  localparam cause_t CAUSE_POR_VAL = cause_t'(1) << CAUSE_POR;
endpackage

// File: rtl/rst_sync.sv
`timescale 1ns/1ps
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_in,
  output logic rst_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge arst_in) begin
    if (arst_in) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b0};
  end

  assign rst_out = chain_q[STAGES-1];
endmodule

// File: rtl/rst_stage.sv
`timescale 1ns/1ps
module rst_stage #(
  parameter int CYCLES      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_in,
  output logic rst_out
);
  localparam int CW = $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - SYNC_STAGES - 1);

  logic          in_sync;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .arst_in (arst_in),
    .rst_out (in_sync)
  );

  // Counter and output are forced back to the start by any reassertion.
  always_ff @(posedge clk or posedge arst_in) begin
    if (arst_in) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else if (out_q && !in_sync) begin
      if (cnt_q == LAST) out_q <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rst_out = out_q;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (arst_in)
    cnt_q <= LAST);

  assert_hold_while_sync_R4: assert property (@(posedge clk) disable iff (arst_in)
    in_sync |-> rst_out);

  assert_release_after_sync_R4: assert property (@(posedge clk) disable iff (arst_in)
    $fell(rst_out) |-> !$past(in_sync));
endmodule

// File: rtl/rst_seq_top.sv
`timescale 1ns/1ps
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int POR_STRETCH = 64,
  parameter int CLKGEN_CYC  = 32,
  parameter int PERIPH_CYC  = 32,
  parameter int CORE_CYC    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               osc_clk,
  input  logic               sys_clk,
  input  logic               por_n,
  input  logic               ext_rst_n,
  input  logic               wdog_rst,
  input  logic               sw_rst,
  output logic               clkgen_rst,
  output logic               periph_rst,
  output logic               core_rst,
  output logic [CAUSE_W-1:0] cause
);
  logic               por_req;
  logic               por_long;
  logic [NUM_SRC-1:0] src_raw;
  logic [NUM_SRC-1:0] src_sync;
  logic               comb_rst;
  logic               armed_q;
  cause_t             cause_q;

  assign por_req = ~por_n;
  assign src_raw = {sw_rst, wdog_rst, ~ext_rst_n};

  // Power-on stretch on the oscillator clock.
  rst_stage #(.CYCLES(POR_STRETCH), .SYNC_STAGES(SYNC_STAGES)) u_por_stage (
    .clk     (osc_clk),
    .arst_in (por_req),
    .rst_out (por_long)
  );

  // Per-source synchronizers with asynchronous set.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    rst_sync #(.STAGES(SYNC_STAGES)) u_src_sync (
      .clk     (osc_clk),
      .arst_in (src_raw[s]),
      .rst_out (src_sync[s])
    );
  end

  assign comb_rst = por_long | (|src_sync);

  rst_stage #(.CYCLES(CLKGEN_CYC), .SYNC_STAGES(SYNC_STAGES)) u_clkgen_stage (
    .clk     (osc_clk),
    .arst_in (comb_rst),
    .rst_out (clkgen_rst)
  );

  rst_stage #(.CYCLES(PERIPH_CYC), .SYNC_STAGES(SYNC_STAGES)) u_periph_stage (
    .clk     (sys_clk),
    .arst_in (clkgen_rst),
    .rst_out (periph_rst)
  );

  rst_stage #(.CYCLES(CORE_CYC), .SYNC_STAGES(SYNC_STAGES)) u_core_stage (
    .clk     (sys_clk),
    .arst_in (periph_rst),
    .rst_out (core_rst)
  );

  // Cause record: armed while idle, captures on the first edge of a sequence.
  always_ff @(posedge osc_clk or posedge por_req) begin
    if (por_req) begin
      armed_q <= 1'b0;
      cause_q <= CAUSE_POR_VAL;
    end else begin
      armed_q <= ~clkgen_rst;
      if (armed_q && (|src_sync)) cause_q <= {src_sync, 1'b0};
    end
  end

  assign cause = cause_q;

  assert_order_periph_R6: assert property (@(posedge sys_clk) disable iff (!por_n)
    !periph_rst |-> !clkgen_rst);

  assert_order_core_R6: assert property (@(posedge sys_clk) disable iff (!por_n)
    !core_rst |-> !periph_rst);

  assert_hold_downstream_R7: assert property (@(posedge osc_clk) disable iff (!por_n)
    clkgen_rst |-> (periph_rst && core_rst));

  assert_cause_nonzero_R8: assert property (@(posedge osc_clk) disable iff (!por_n)
    $countones(cause_q) >= 1);

  assert_cause_frozen_R8: assert property (@(posedge osc_clk) disable iff (!por_n)
    !$past(armed_q) |-> $stable(cause_q));
endmodule

// File: tb/rst_seq_top_tb.sv
`timescale 1ns/1ps
module rst_seq_top_tb;
  logic osc_clk = 1'b0;
  logic sys_raw = 1'b0;
  logic sys_en  = 1'b1;
  logic sys_clk;
  logic por_n = 1'b1, ext_rst_n = 1'b1, wdog_rst = 1'b0, sw_rst = 1'b0;
  logic clkgen_rst, periph_rst, core_rst;
  logic [3:0] cause;
  int total = 0;
  int bad   = 0;

  assign sys_clk = sys_raw & sys_en;

  always #5 osc_clk = ~osc_clk;
  initial begin
    #2;
    forever begin sys_raw = 1'b1; #6; sys_raw = 1'b0; #6; end
  end

  rst_seq_top u_dut (
    .osc_clk(osc_clk), .sys_clk(sys_clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .wdog_rst(wdog_rst), .sw_rst(sw_rst), .clkgen_rst(clkgen_rst),
    .periph_rst(periph_rst), .core_rst(core_rst), .cause(cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_cause(input int src); // 0 ext, 1 wdog, 2 sw
    return 1 << (src + 1);
  endfunction

  task automatic drive_src(input int src, input logic on);
    case (src)
      0: ext_rst_n = ~on;
      1: wdog_rst  = on;
      default: sw_rst = on;
    endcase
  endtask

  task automatic sys_release();
    repeat (31) @(posedge sys_clk);
    #0.5 chk("R5 periph before edge 32", periph_rst, 1);
    @(posedge sys_clk);
    #0.5 chk("R5 periph at edge 32", periph_rst, 0);
    chk("R6 core still held", core_rst, 1);
    repeat (31) @(posedge sys_clk);
    #0.5 chk("R6 core before edge 32", core_rst, 1);
    @(posedge sys_clk);
    #0.5 chk("R6 core at edge 32", core_rst, 0);
  endtask

  task automatic full_release(input int osc_n, input string tag);
    repeat (osc_n - 1) @(posedge osc_clk);
    #0.5 chk({tag, " clkgen before release"}, clkgen_rst, 1);
    @(posedge osc_clk);
    #0.5 chk({tag, " clkgen release edge"}, clkgen_rst, 0);
    chk("R6 periph held after clkgen", periph_rst, 1);
    sys_release();
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1 por_n = 1'b0;
    #2;
    chk("R2 clkgen on power-on", clkgen_rst, 1);
    chk("R2 periph on power-on", periph_rst, 1);
    chk("R2 core on power-on", core_rst, 1);
    chk("R9 cause on power-on", cause, 1);
    repeat (20) @(posedge osc_clk);
    #0.5 por_n = 1'b1;
    full_release(96, "R1");
    chk("R9 cause after power-on", cause, 1);
    chk("R10 idle no reset", clkgen_rst | periph_rst | core_rst, 0);

    // R2/R3/R8 random requests
    for (int it = 0; it < 8; it++) begin
      int src;
      int hold;
      src  = $urandom % 3;
      hold = 1 + ($urandom % 20);
      repeat (3) @(posedge osc_clk);
      #0.5 drive_src(src, 1'b1);
      #0.2 chk("R2 all asserted", {clkgen_rst, periph_rst, core_rst}, 7);
      repeat (hold) @(posedge osc_clk);
      #0.5 drive_src(src, 1'b0);
      full_release(34, "R3");
      chk("R8 cause of random request", cause, exp_cause(src));
    end

    // R4: a short glitch during the count restarts it
    @(posedge osc_clk);
    #0.5 ext_rst_n = 1'b0;
    repeat (4) @(posedge osc_clk);
    #0.5 ext_rst_n = 1'b1;
    repeat (20) @(posedge osc_clk);
    #0.5 ext_rst_n = 1'b0;
    #0.3 ext_rst_n = 1'b1;
    full_release(34, "R4");
    chk("R9 cause not cleared by external", cause, exp_cause(0));

    // R8: later request during a sequence leaves cause alone
    @(posedge osc_clk);
    #0.5 wdog_rst = 1'b1;
    repeat (5) @(posedge osc_clk);
    #0.5 wdog_rst = 1'b0;
    repeat (10) @(posedge osc_clk);
    #0.5 sw_rst = 1'b1;
    repeat (3) @(posedge osc_clk);
    #0.5 sw_rst = 1'b0;
    full_release(34, "R4 second request");
    chk("R8 cause keeps first request", cause, exp_cause(1));

    // R7: stopped system clock
    @(negedge sys_raw);
    sys_en = 1'b0;
    @(posedge osc_clk);
    #0.5 sw_rst = 1'b1;
    #0.2 chk("R7 periph asserts without sys clock", periph_rst, 1);
    chk("R7 core asserts without sys clock", core_rst, 1);
    repeat (4) @(posedge osc_clk);
    #0.5 sw_rst = 1'b0;
    repeat (40) @(posedge osc_clk);
    #0.5 chk("R7 clkgen released", clkgen_rst, 0);
    chk("R7 periph held while clock stopped", periph_rst, 1);
    chk("R7 core held while clock stopped", core_rst, 1);
    @(negedge sys_raw);
    sys_en = 1'b1;
    sys_release();
    chk("R8 cause software", cause, exp_cause(2));

    // R9: second power-on resets the record
    @(posedge osc_clk);
    #0.5 por_n = 1'b0;
    #0.2 chk("R9 cause cleared by power-on", cause, 1);
    repeat (6) @(posedge osc_clk);
    #0.5 por_n = 1'b1;
    full_release(96, "R1 second");
    chk("R10 idle after all", clkgen_rst | periph_rst | core_rst, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule